// File: doc/BRIEF.md
# SMIC host transaction engine

This block is the host-side sequencer for a three-register management mailbox. Software, or another block, loads a request of 2 to 80 bytes into an internal buffer and pulses `start`. The engine then carries the message across the mailbox on its own. It steps through paired control and status codes and watches the device's BUSY, TX-ready and RX-ready flags. It collects the response into a second buffer and raises `done` when the exchange ends cleanly.

Every command step follows the same pattern: the control code is written, then a data byte if the step carries one, then the flags register with BUSY set. After that the engine only polls the flags until the device clears BUSY. A wrong status, a non-zero error byte at either end of the exchange, or a cycle timeout restarts the whole message from its first byte. After a fixed number of retries the engine parks in a fault state until the next start. The response is read through a random-access byte port. When the response is short or was cut off, the completion code position (byte 2) is replaced.

Top module: `smic_host_seq`

## Requirements
- R1: After reset the engine is inactive: `busy`, `done`, `hosed`, `mb_rd` and `mb_wr` are all 0.
- R2: A start is accepted only while the engine is not busy and only when `start_len` is between 2 and MAX_REQ. Any other start raises `start_rej` in the following cycle and causes no mailbox access.
- R3: The mailbox map is data at offset 0, control/status at offset 1 and flags at offset 2, where bit 7 is RX ready, bit 6 is TX ready and bit 0 is BUSY. Each command is a control write, an optional data write, then a flags write with bit 0 set. The engine writes nothing to offsets 0 and 1 while the device's BUSY is set.
- R4: The write phase sends 0x40 (get status). On status 0xC0 it sends 0x41 with request byte 0. After that it sends one byte per step: with 0x42 while more than one byte remains, and with 0x43 for the last byte. It never issues 0x42 or 0x43 unless TX ready is set. The device receives the request bytes in order.
- R5: After status 0xC3 the data register holds an error byte, and a non-zero value is a fault. Otherwise the engine waits for RX ready before it sends 0x44.
- R6: In the read phase, status 0xC4 or 0xC5 with RX ready captures a byte and sends 0x45. Status 0xC6 captures the last byte and sends 0x46. Status 0xC0 with a zero data byte then ends the exchange: `done` pulses for one cycle and `rsp_len` holds the number of bytes captured.
- R7: An unexpected status or a non-zero error byte restarts the message from byte 0 with a fresh 0x40. The fault that would make the retry count exceed MAX_RETRY instead enters the hosed state (`hosed` = 1, no mailbox access), and a later valid start is accepted from there.
- R8: If TMO_CYC cycles pass without a completed step while the engine is busy, that counts as a fault under R7.
- R9: Response bytes beyond MAX_RSP are read and discarded, `rsp_trunc` is set, `rsp_len` stays at MAX_RSP, and `rsp_byte` at index 2 reads TRUNC_CC.
- R10: When fewer than 3 response bytes were captured, `rsp_byte` at index 2 reads UNSPEC_CC.
- R11: Writes to the request buffer are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Request buffer write enable |
| ld_idx | input | QW | Request buffer byte index |
| ld_byte | input | 8 | Request buffer byte |
| start | input | 1 | Start pulse |
| start_len | input | LW | Request length in bytes |
| start_rej | output | 1 | Start was refused (one cycle) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction completed (one cycle) |
| hosed | output | 1 | Retries exhausted |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_off | output | 2 | Mailbox register offset |
| mb_wdata | output | 8 | Mailbox write data |
| mb_rdata | input | 8 | Mailbox read data, valid in the cycle of `mb_rd` |
| rsp_idx | input | PW | Response byte index |
| rsp_byte | output | 8 | Response byte at `rsp_idx` |
| rsp_len | output | PW | Number of response bytes held |
| rsp_trunc | output | 1 | Response exceeded the buffer |

## Verification
The bench keeps the full 80-byte buffers, so an 83-byte response reaches truncation and the discard path. It uses an ordinary retry limit of 3, which makes the fourth consecutive fault the one that parks the engine. The timeout is reduced to 60 cycles. With that value a device that holds BUSY forever exhausts all retries within a few hundred cycles, and the measured time until the fault state is bounded from both sides.

// File: rtl/smic_host_seq.sv
module smic_host_seq #(
  parameter int MAX_REQ = 80,
  parameter int MAX_RSP = 80,
  parameter int MAX_RETRY = 3,
  parameter int TMO_CYC = 100000,
  parameter logic [7:0] UNSPEC_CC = 8'hFF,
  parameter logic [7:0] TRUNC_CC = 8'hC6,
  parameter int QW = $clog2(MAX_REQ),
  parameter int LW = $clog2(MAX_REQ + 1),
  parameter int PW = $clog2(MAX_RSP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [QW-1:0] ld_idx,
  input  logic [7:0]    ld_byte,
  input  logic          start,
  input  logic [LW-1:0] start_len,
  output logic          start_rej,
  output logic          busy,
  output logic          done,
  output logic          hosed,
  output logic          mb_rd,
  output logic          mb_wr,
  output logic [1:0]    mb_off,
  output logic [7:0]    mb_wdata,
  input  logic [7:0]    mb_rdata,
  input  logic [PW-1:0] rsp_idx,
  output logic [7:0]    rsp_byte,
  output logic [PW-1:0] rsp_len,
  output logic          rsp_trunc
);
  localparam int RQ = $clog2(MAX_RSP);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LD = TW'(TMO_CYC);

  localparam logic [7:0] C_GET = 8'h40, C_WST = 8'h41, C_WNX = 8'h42, C_WEND = 8'h43;
  localparam logic [7:0] C_RST = 8'h44, C_RNX = 8'h45, C_REND = 8'h46;
  localparam logic [7:0] S_BIT = 8'h80;

  typedef enum logic [3:0] {
    S_IDLE, S_HOSED, S_GETST, S_OPOK, S_WRST, S_WRNX, S_WREND,
    S_TURN, S_RDST, S_RDNX, S_RDEND
  } st_t;

  typedef enum logic [2:0] {P_FLG, P_STS, P_DAT, P_CTL, P_WD, P_WF} ph_t;

  st_t st, nst, d_nst;
  ph_t ph;
  logic [7:0] ctl, d_ctl;
  logic wd, d_wd, d_wait, d_rdat, d_fault;
  logic f_rx, f_tx;
  logic [LW-1:0] len, wpos;
  logic [PW-1:0] rpos;
  logic trunc;
  logic [RW-1:0] retry;
  logic [TW-1:0] tmo;
  logic done_q, rej_q;
  logic [7:0] wbuf [MAX_REQ];
  logic [7:0] rbuf [MAX_RSP];

  logic active, acc, flt, tmo_hit, err_hit, end_st, last_one;
  logic [7:0] sts;

  assign active = (st != S_IDLE) && (st != S_HOSED);
  assign acc = start && !active && (start_len >= LW'(2)) && (int'(start_len) <= MAX_REQ);
  assign sts = mb_rdata;
  assign end_st = (st == S_WREND) || (st == S_RDEND);
  assign last_one = (len - wpos) == LW'(1);
  assign tmo_hit = (ph == P_FLG) && (tmo == '0);
  assign err_hit = (ph == P_DAT) && end_st && (mb_rdata != 8'h00);
  assign flt = active && (tmo_hit || ((ph == P_STS) && d_fault) || err_hit);

  always_comb begin
    d_fault = 1'b0;
    d_wait = 1'b0;
    d_rdat = 1'b0;
    d_wd = 1'b0;
    d_ctl = C_GET;
    d_nst = st;
    case (st)
      S_GETST: d_nst = S_OPOK;
      S_OPOK:
        if (sts != (C_GET | S_BIT)) d_fault = 1'b1;
        else begin d_ctl = C_WST; d_wd = 1'b1; d_nst = S_WRST; end
      S_WRST, S_WRNX:
        if (sts != (((st == S_WRST) ? C_WST : C_WNX) | S_BIT)) d_fault = 1'b1;
        else if (!f_tx) d_wait = 1'b1;
        else begin
          d_wd = 1'b1;
          d_ctl = last_one ? C_WEND : C_WNX;
          d_nst = last_one ? S_WREND : S_WRNX;
        end
      S_WREND:
        if (sts != (C_WEND | S_BIT)) d_fault = 1'b1;
        else d_rdat = 1'b1;
      S_TURN:
        if (!f_rx) d_wait = 1'b1;
        else begin d_ctl = C_RST; d_nst = S_RDST; end
      S_RDST:
        if (sts != (C_RST | S_BIT)) d_fault = 1'b1;
        else if (!f_rx) d_wait = 1'b1;
        else begin d_rdat = 1'b1; d_ctl = C_RNX; d_nst = S_RDNX; end
      S_RDNX:
        if (sts == (C_REND | S_BIT)) begin d_rdat = 1'b1; d_ctl = C_REND; d_nst = S_RDEND; end
        else if (sts != (C_RNX | S_BIT)) d_fault = 1'b1;
        else if (!f_rx) d_wait = 1'b1;
        else begin d_rdat = 1'b1; d_ctl = C_RNX; d_nst = S_RDNX; end
      S_RDEND:
        if (sts != (C_GET | S_BIT)) d_fault = 1'b1;
        else d_rdat = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nst <= S_IDLE;
      ph <= P_FLG;
      ctl <= 8'h00;
      wd <= 1'b0;
      f_rx <= 1'b0;
      f_tx <= 1'b0;
      len <= '0;
      wpos <= '0;
      rpos <= '0;
      trunc <= 1'b0;
      retry <= '0;
      tmo <= '0;
      done_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q <= start && !acc;
      if (active && (tmo != '0)) tmo <= tmo - 1'b1;
      if (acc) begin
        st <= S_GETST;
        ph <= P_FLG;
        len <= start_len;
        wpos <= '0;
        rpos <= '0;
        trunc <= 1'b0;
        retry <= '0;
        tmo <= TMO_LD;
      end else if (flt) begin
        retry <= retry + 1'b1;
        if (int'(retry) >= MAX_RETRY) st <= S_HOSED;
        else begin
          st <= S_GETST;
          ph <= P_FLG;
          wpos <= '0;
          rpos <= '0;
          trunc <= 1'b0;
          tmo <= TMO_LD;
        end
      end else if (active) begin
        case (ph)
          P_FLG: begin
            f_rx <= mb_rdata[7];
            f_tx <= mb_rdata[6];
            if (!mb_rdata[0]) ph <= P_STS;
          end
          P_STS:
            if (d_wait) ph <= P_FLG;
            else begin
              ctl <= d_ctl;
              wd <= d_wd;
              nst <= d_nst;
              ph <= d_rdat ? P_DAT : P_CTL;
            end
          P_DAT:
            if (st == S_WREND) begin
              st <= S_TURN;
              ph <= P_FLG;
              tmo <= TMO_LD;
            end else if (st == S_RDEND) begin
              st <= S_IDLE;
              ph <= P_FLG;
              done_q <= 1'b1;
            end else begin
              if (int'(rpos) < MAX_RSP) rpos <= rpos + 1'b1;
              else trunc <= 1'b1;
              ph <= P_CTL;
            end
          P_CTL: ph <= wd ? P_WD : P_WF;
          P_WD: begin
            wpos <= wpos + 1'b1;
            ph <= P_WF;
          end
          P_WF: begin
            st <= nst;
            ph <= P_FLG;
            tmo <= TMO_LD;
          end
          default: ph <= P_FLG;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we && !active && (int'(ld_idx) < MAX_REQ)) wbuf[ld_idx] <= ld_byte;
  end

  always_ff @(posedge clk) begin
    if (active && !flt && (ph == P_DAT) && !end_st && (int'(rpos) < MAX_RSP))
      rbuf[rpos[RQ-1:0]] <= mb_rdata;
  end

  assign mb_rd = active && ((ph == P_FLG) || (ph == P_STS) || (ph == P_DAT));
  assign mb_wr = active && ((ph == P_CTL) || (ph == P_WD) || (ph == P_WF));
  assign mb_off = ((ph == P_FLG) || (ph == P_WF)) ? 2'd2 :
                  ((ph == P_STS) || (ph == P_CTL)) ? 2'd1 : 2'd0;
  assign mb_wdata = (ph == P_CTL) ? ctl :
                    (ph == P_WD)  ? wbuf[wpos[QW-1:0]] :
                    (ph == P_WF)  ? {f_rx, f_tx, 6'b000001} : 8'h00;

  assign rsp_byte = (rsp_idx == PW'(2) && trunc) ? TRUNC_CC :
                    (rsp_idx == PW'(2) && rpos < PW'(3)) ? UNSPEC_CC :
                    (int'(rsp_idx) < MAX_RSP) ? rbuf[rsp_idx[RQ-1:0]] : 8'h00;

  assign start_rej = rej_q;
  assign busy = active;
  assign done = done_q;
  assign hosed = (st == S_HOSED);
  assign rsp_len = rpos;
  assign rsp_trunc = trunc;
endmodule

// File: rtl/smic_host_seq_chk.sv
module smic_host_seq_chk #(
  parameter int MAX_RSP = 80,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          hosed,
  input logic          mb_rd,
  input logic          mb_wr,
  input logic [1:0]    mb_off,
  input logic [7:0]    mb_wdata,
  input logic [PW-1:0] rsp_len,
  input logic          rsp_trunc
);
  a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_rd && mb_wr));

  a_r3_valid_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_rd || mb_wr) |-> (mb_off != 2'd3));

  a_r3_flags_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_off == 2'd2) |-> mb_wdata[0]);

  a_r3_ctl_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_off == 2'd1) |=> (mb_wr && mb_off != 2'd1));

  a_r7_hosed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hosed |-> (!mb_rd && !mb_wr && !busy));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_trunc_full: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trunc |-> (int'(rsp_len) == MAX_RSP));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind smic_host_seq smic_host_seq_chk #(.MAX_RSP(MAX_RSP), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hosed(hosed), .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_off(mb_off),
  .mb_wdata(mb_wdata), .rsp_len(rsp_len), .rsp_trunc(rsp_trunc)
);

// File: tb/test_smic_host_seq.sv
module test_smic_host_seq;
  localparam int TMO = 60;
  localparam int LAT = 2;
  localparam int TXD = 2;
  localparam int RXD = 3;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [6:0] ld_idx = '0;
  logic [7:0] ld_byte = '0;
  logic start = 1'b0;
  logic [6:0] start_len = '0;
  logic start_rej, busy, done, hosed, mb_rd, mb_wr, rsp_trunc;
  logic [1:0] mb_off;
  logic [7:0] mb_wdata, mb_rdata, rsp_byte;
  logic [6:0] rsp_idx = '0;
  logic [6:0] rsp_len;

  always #5 clk = ~clk;

  smic_host_seq #(.TMO_CYC(TMO)) i_smic_host_seq (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx), .ld_byte(ld_byte),
    .start(start), .start_len(start_len), .start_rej(start_rej), .busy(busy),
    .done(done), .hosed(hosed), .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_off(mb_off),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata), .rsp_idx(rsp_idx),
    .rsp_byte(rsp_byte), .rsp_len(rsp_len), .rsp_trunc(rsp_trunc)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural mailbox device and protocol reference
  logic m_busy, m_rx, m_tx, stall, exp_done;
  logic [7:0] m_sts, m_data, m_ctl, m_dat, last_ctl;
  logic [7:0] cap[$];
  logic [7:0] rsp_q[$];
  logic [7:0] req[$];
  int lat, txd, rxd, ridx, bad_gs, wr_err_n, rd_err_n, n_gs, n_wst, acc_cnt;

  assign mb_rdata = (mb_off == 2'd2) ? {m_rx, m_tx, 5'b0, m_busy} :
                    (mb_off == 2'd1) ? m_sts : m_data;

  task automatic serve();
    m_busy = 1'b0;
    last_ctl = m_ctl;
    case (m_ctl)
      8'h40: begin
        n_gs++;
        m_rx = 1'b0; m_tx = 1'b0;
        if (bad_gs > 0) begin bad_gs--; m_sts = 8'hC5; end
        else m_sts = 8'hC0;
      end
      8'h41: begin
        n_wst++; cap.delete(); cap.push_back(m_dat);
        m_sts = 8'hC1; m_tx = 1'b0; txd = TXD;
      end
      8'h42: begin cap.push_back(m_dat); m_sts = 8'hC2; m_tx = 1'b0; txd = TXD; end
      8'h43: begin
        cap.push_back(m_dat); m_sts = 8'hC3; m_tx = 1'b0;
        if (wr_err_n > 0) begin wr_err_n--; m_data = 8'h05; end
        else m_data = 8'h00;
        m_rx = 1'b0; rxd = RXD;
      end
      8'h44: begin ridx = 0; m_data = rsp_q[0]; m_sts = 8'hC4; m_rx = 1'b1; end
      8'h45: begin
        ridx++; m_data = rsp_q[ridx];
        m_sts = (ridx == rsp_q.size() - 1) ? 8'hC6 : 8'hC5; m_rx = 1'b1;
      end
      8'h46: begin
        m_sts = 8'hC0; m_rx = 1'b0;
        if (rd_err_n > 0) begin rd_err_n--; m_data = 8'h01; end
        else m_data = 8'h00;
      end
      default: m_sts = 8'h00;
    endcase
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rx = 0; m_tx = 0; stall = 0; exp_done = 0;
      m_sts = 8'hC0; m_data = 0; m_ctl = 0; m_dat = 0; last_ctl = 0;
      lat = 0; txd = 0; rxd = 0; ridx = 0; bad_gs = 0; wr_err_n = 0; rd_err_n = 0;
      n_gs = 0; n_wst = 0; acc_cnt = 0;
    end else begin
      // R6: done compared against the device-side prediction on every clock
      chk(done === exp_done, "R6 done timing", int'(done), int'(exp_done));
      exp_done = mb_rd && mb_off == 2'd0 && last_ctl == 8'h46 && m_sts == 8'hC0 && m_data == 8'h00;
      if (txd > 0) begin txd--; if (txd == 0) m_tx = 1'b1; end
      if (rxd > 0) begin rxd--; if (rxd == 0) m_rx = 1'b1; end
      if (m_busy && !stall) begin
        if (lat == 0) serve(); else lat--;
      end
      if (mb_rd || mb_wr) acc_cnt++;
      if (mb_wr) begin
        if (mb_off != 2'd2) chk(!m_busy, "R3 write while busy", int'(m_busy), 0);
        case (mb_off)
          2'd1: begin
            m_ctl = mb_wdata;
            if (mb_wdata == 8'h42 || mb_wdata == 8'h43) chk(m_tx, "R4 tx gate", int'(m_tx), 1);
            if (mb_wdata == 8'h44) chk(m_rx, "R5 rx gate", int'(m_rx), 1);
            if (mb_wdata == 8'h45) chk(m_rx, "R6 rx gate", int'(m_rx), 1);
          end
          2'd0: m_dat = mb_wdata;
          2'd2: begin
            chk(mb_wdata[0], "R3 busy bit", int'(mb_wdata[0]), 1);
            m_busy = 1'b1; lat = LAT;
          end
          default: chk(1'b0, "R3 offset", int'(mb_off), 2);
        endcase
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(negedge clk) if (cyc == WD) begin
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD);
    summary();
  end

  task automatic load_req(input int n, input int seed);
    req.delete();
    for (int i = 0; i < n; i++) begin
      req.push_back(8'(seed + i * 7));
      @(negedge clk); ld_we = 1'b1; ld_idx = 7'(i); ld_byte = req[i];
    end
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic set_rsp(input int n, input int seed);
    rsp_q.delete();
    for (int i = 0; i < n; i++) rsp_q.push_back(8'(seed + i * 3));
  endtask

  task automatic kick(input int n, output bit rej);
    @(negedge clk); start = 1'b1; start_len = 7'(n);
    @(negedge clk); start = 1'b0;
    rej = start_rej;
  endtask

  task automatic wait_end(output int cycles);
    cycles = 0;
    while (!done && !hosed && cycles < 20000) begin @(negedge clk); cycles++; end
  endtask

  task automatic chk_req(input string tag);
    chk(cap.size() == req.size(), tag, cap.size(), req.size());
    for (int i = 0; i < req.size() && i < cap.size(); i++)
      if (cap[i] != req[i]) chk(1'b0, tag, int'(cap[i]), int'(req[i]));
  endtask

  task automatic chk_rsp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i == 2) continue;
      rsp_idx = 7'(i); #1;
      if (rsp_byte != rsp_q[i]) chk(1'b0, tag, int'(rsp_byte), int'(rsp_q[i]));
    end
    chk(1'b1, tag, 0, 0);
  endtask

  task automatic txn(input int nq, input int nr, input int seed, input string tag);
    bit rej;
    int c;
    load_req(nq, seed);
    set_rsp(nr, seed + 100);
    kick(nq, rej);
    chk(!rej, {tag, " accepted"}, int'(rej), 0);
    wait_end(c);
    chk(done === 1'b1, {tag, " done"}, int'(done), 1);
  endtask

  initial begin
    bit rej;
    int c, a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !hosed && !mb_rd && !mb_wr, "R1 reset state",
        int'({busy, done, hosed, mb_rd, mb_wr}), 0);

    // R4/R6 basic exchange
    txn(5, 6, 8'h11, "R4 basic");
    chk_req("R4 request order");
    chk(int'(rsp_len) == 6, "R6 rsp_len", int'(rsp_len), 6);
    rsp_idx = 7'd2; #1;
    chk(rsp_byte == rsp_q[2], "R6 byte2", int'(rsp_byte), int'(rsp_q[2]));
    chk_rsp(6, "R6 response bytes");
    chk(n_gs == 1 && n_wst == 1, "R4 single attempt", n_gs * 10 + n_wst, 11);

    // R10 minimum request, two-byte response
    txn(2, 2, 8'h30, "R10 short");
    chk_req("R4 two-byte request");
    chk(int'(rsp_len) == 2, "R10 rsp_len", int'(rsp_len), 2);
    rsp_idx = 7'd2; #1;
    chk(rsp_byte == 8'hFF, "R10 unspecified code", int'(rsp_byte), 255);

    // R2 rejected lengths
    a0 = acc_cnt;
    kick(1, rej);
    chk(rej, "R2 len 1 rejected", int'(rej), 1);
    kick(81, rej);
    chk(rej, "R2 len 81 rejected", int'(rej), 1);
    repeat (5) @(negedge clk);
    chk(acc_cnt == a0 && !busy, "R2 no access after reject", acc_cnt - a0, 0);

    // R2 start while busy, R11 load ignored while busy
    load_req(8, 8'h50);
    set_rsp(4, 8'h70);
    kick(8, rej);
    chk(!rej, "R2 accepted", int'(rej), 0);
    repeat (4) @(negedge clk);
    ld_we = 1'b1; ld_idx = 7'd0; ld_byte = 8'hEE;
    @(negedge clk); ld_we = 1'b0;
    kick(8, rej);
    chk(rej, "R2 start while busy", int'(rej), 1);
    wait_end(c);
    chk(done === 1'b1, "R2 busy txn done", int'(done), 1);
    chk_req("R11 load ignored");

    // R7 unexpected status once
    n_gs = 0; bad_gs = 1;
    txn(4, 3, 8'h21, "R7 bad status");
    chk(n_gs == 2, "R7 restart count", n_gs, 2);
    chk_req("R7 full resend");

    // R5 write-end error once
    n_wst = 0; wr_err_n = 1;
    txn(6, 5, 8'h41, "R5 write error");
    chk(n_wst == 2, "R5 restart from byte 0", n_wst, 2);
    chk_req("R5 full resend");

    // R7 read-end error once
    n_wst = 0; rd_err_n = 1;
    txn(3, 5, 8'h61, "R7 read error");
    chk(n_wst == 2, "R7 restart after read error", n_wst, 2);
    chk(int'(rsp_len) == 5, "R7 rsp_len after retry", int'(rsp_len), 5);
    chk_rsp(5, "R7 response after retry");

    // R7 retries exhausted
    n_wst = 0; wr_err_n = 4;
    load_req(3, 8'h05); set_rsp(3, 8'h09);
    kick(3, rej);
    wait_end(c);
    chk(hosed === 1'b1 && !busy, "R7 hosed", int'(hosed), 1);
    chk(n_wst == 4, "R7 attempt count", n_wst, 4);
    a0 = acc_cnt;
    repeat (10) @(negedge clk);
    chk(acc_cnt == a0 && !done, "R7 quiet when hosed", acc_cnt - a0, 0);

    // R7 start accepted from hosed
    txn(4, 4, 8'h33, "R7 from hosed");
    chk(!hosed, "R7 hosed cleared", int'(hosed), 0);

    // R8 timeout: device never clears busy
    stall = 1'b1;
    load_req(3, 8'h44); set_rsp(3, 8'h45);
    kick(3, rej);
    wait_end(c);
    chk(hosed === 1'b1, "R8 timeout hosed", int'(hosed), 1);
    chk(c >= 4 * TMO && c <= 4 * (TMO + 12) + 30, "R8 timeout window", c, 4 * TMO);
    stall = 1'b0;
    repeat (10) @(negedge clk);
    txn(3, 3, 8'h47, "R8 recovery");

    // R9 truncation
    txn(2, 83, 8'h02, "R9 long");
    chk(int'(rsp_len) == 80 && rsp_trunc, "R9 trunc", int'(rsp_len), 80);
    rsp_idx = 7'd2; #1;
    chk(rsp_byte == 8'hC6, "R9 truncated code", int'(rsp_byte), 198);
    rsp_idx = 7'd79; #1;
    chk(rsp_byte == rsp_q[79], "R9 last kept byte", int'(rsp_byte), int'(rsp_q[79]));
    rsp_idx = 7'd0; #1;
    chk(rsp_byte == rsp_q[0], "R9 first byte", int'(rsp_byte), int'(rsp_q[0]));

    // R9 flag cleared by the next exchange
    txn(2, 4, 8'h12, "R9 clear");
    chk(!rsp_trunc && int'(rsp_len) == 4, "R9 trunc cleared", int'(rsp_trunc), 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule